// File: doc/BRIEF.md
# Copy-Engine Interrupt Status and Coalescing Unit

This unit collects completion events from a descriptor-based copy engine and turns them into one level-sensitive interrupt line. Every transmit queue and every receive queue has a sticky done bit in a status word. In addition, each direction has its own coalescing stage. It counts completions and raises a delayed-interrupt bit in one of two cases: when enough events have piled up, or when a time budget, measured in ticks of a free-running timebase, has passed since events started pending.

Software programs three words over a simple read/write bus: the mask, the coalescing configuration and the status. To acknowledge events, software writes the value it read back to the status word. Each one written clears its bit. A completion that arrives in the same cycle as a clear keeps its bit set, so no event is lost. The interrupt output is high whenever any status bit is set together with its mask bit.

Top module: `hs_irq_coalesce`

## Requirements
- R1: After reset the status, mask and coalescing words all read zero and `irq` is low.
- R2: A pulse on `tx_done[i]` sets status bit i (bits 3:0), and a pulse on `rx_done[j]` sets status bit 16+j (bits 17:16). The bits stay set until cleared, and every other status bit reads zero unless a delayed interrupt sets it.
- R3: A bus write to offset 0x220 clears every status bit whose written data bit is one. Bits written as zero, and bits that have no function, are left unchanged.
- R4: If a completion and a clear hit the same status bit in the same cycle, the bit is set afterwards.
- R5: Offset 0x228 is the mask. It reads back only the implemented bits (0xF003000F). The `irq` output goes high in the cycle after an event whose status bit is masked on, and stays low while no set status bit is masked on.
- R6: Offset 0x20C is the coalescing word. It reads back all 32 bits as written. The transmit half is bits 31:16 and the receive half is bits 15:0. Within each half, bit 15 is the enable, bits 14:8 the count threshold and bits 7:0 the tick limit.
- R7: With a half enabled and threshold N nonzero, the delayed bit (28 for transmit, 30 for receive) is set in the cycle after the completion that brings the pending count to N. Several completions in one cycle each count. The count then restarts from zero.
- R8: With a half enabled, tick limit L nonzero and at least one event pending, the delayed bit is set in the cycle after the L-th tick that follows the cycle in which the first pending event arrived.
- R9: A threshold or limit of zero disables that trigger. A half whose enable is clear never sets its delayed bit.
- R10: The companion bits 29 (transmit) and 31 (receive) are set in the same cycle as their delayed bits 28 and 30.
- R11: Completions in one direction never advance the coalescing count of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done | input | TX_Q (4) | Per-queue transmit completion pulses |
| rx_done | input | RX_Q (2) | Per-queue receive completion pulses |
| tick | input | 1 | Free-running timebase pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The status path is driven by a table of single-queue pulses, pulses from both directions at once, plain clears, zero writes, and a clear that lands on a bit being set in the same cycle. Together these separate sticky setting, write-one-to-clear and set priority. Coalescing is tried three ways. A multi-pulse cycle that reaches the count threshold shows that pulses in one cycle are counted one by one. A tick sequence that stops one tick short of the limit and then reaches it pins down when the timer fires. Enabled halves with zero fields, and programmed halves with the enable clear, show that each trigger can be disabled. Completions in the unconfigured direction are driven to confirm that the two directions stay separate.

// File: rtl/hs_irq_pkg.sv
package hs_irq_pkg;
  localparam int unsigned DLY_THR_W = 7;
  localparam int unsigned DLY_LIM_W = 8;

  localparam logic [11:0] OFS_STAT = 12'h220;
  localparam logic [11:0] OFS_MASK = 12'h228;
  localparam logic [11:0] OFS_DLY  = 12'h20C;

  localparam int unsigned RX_DONE_LSB = 16;
  localparam int unsigned BIT_TX_DLY  = 28;
  localparam int unsigned BIT_TX_COH  = 29;
  localparam int unsigned BIT_RX_DLY  = 30;
  localparam int unsigned BIT_RX_COH  = 31;

  typedef struct packed {
    logic                 en;
    logic [DLY_THR_W-1:0] thr;
    logic [DLY_LIM_W-1:0] lim;
  } dly_half_t;
endpackage

// File: rtl/hs_coal_half.sv
module hs_coal_half
  import hs_irq_pkg::*;
#(
  parameter int unsigned EV_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dly_half_t       cfg,
  input  logic [EV_W-1:0] ev,
  input  logic            tick,
  output logic            fire
);
  localparam int unsigned INC_W = $clog2(EV_W + 1);
  localparam int unsigned SUM_W = DLY_THR_W + 1;
  localparam int unsigned TMR_W = DLY_LIM_W + 1;
  localparam logic [DLY_THR_W-1:0] CNT_MAX = '1;

  logic [DLY_THR_W-1:0] cnt_q, cnt_d;
  logic [DLY_LIM_W-1:0] tmr_q, tmr_d;
  logic [INC_W-1:0]     inc;
  logic [SUM_W-1:0]     sum;
  logic [DLY_THR_W-1:0] sum_sat;
  logic [TMR_W-1:0]     tmr_inc;
  logic                 fire_cnt, fire_tmr, pending, upd;

  always_comb begin
    inc = '0;
    for (int i = 0; i < EV_W; i++) inc = inc + INC_W'(ev[i]);
  end

  always_comb begin
    pending  = (cnt_q != '0);
    sum      = SUM_W'(cnt_q) + SUM_W'(inc);
    sum_sat  = sum[SUM_W-1] ? CNT_MAX : sum[DLY_THR_W-1:0];
    tmr_inc  = {1'b0, tmr_q} + TMR_W'(1);
    fire_cnt = cfg.en && (cfg.thr != '0) && (sum >= {1'b0, cfg.thr});
    fire_tmr = cfg.en && (cfg.lim != '0) && pending && tick &&
               (tmr_inc >= {1'b0, cfg.lim});
    fire     = fire_cnt | fire_tmr;

    if (!cfg.en || fire) begin
      cnt_d = '0;
      tmr_d = '0;
    end else begin
      cnt_d = sum_sat;
      if (pending && tick && !tmr_inc[TMR_W-1]) tmr_d = tmr_inc[DLY_LIM_W-1:0];
      else                                      tmr_d = tmr_q;
    end
    upd = (cnt_d != cnt_q) || (tmr_d != tmr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/hs_stat_reg.sv
module hs_stat_reg #(
  parameter int unsigned     W    = 32,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_d, clr_vec;
  logic         upd;

  always_comb begin
    clr_vec = clr_we ? clr_data : '0;
    stat_d  = ((stat & ~clr_vec) | set_vec) & IMPL;
    upd     = (stat_d != stat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (upd) stat <= stat_d;
  end
endmodule

// File: rtl/hs_irq_coalesce.sv
module hs_irq_coalesce
  import hs_irq_pkg::*;
#(
  parameter int unsigned TX_Q   = 4,
  parameter int unsigned RX_Q   = 2,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TX_Q-1:0]   tx_done,
  input  logic [RX_Q-1:0]   rx_done,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned EV_W = (TX_Q > RX_Q) ? TX_Q : RX_Q;
  localparam logic [31:0] IMPL = (32'((64'd1 << TX_Q) - 64'd1)) |
                                 (32'((64'd1 << RX_Q) - 64'd1) << RX_DONE_LSB) |
                                 32'hF000_0000;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_DLY  = ADDR_W'(OFS_DLY);

  logic [31:0] stat_q, mask_q, mask_d, dly_q, dly_d, set_vec;
  logic        wr_stat, wr_mask, wr_dly;
  logic [1:0]  fire;
  logic [EV_W-1:0] ev_dir [2];
  dly_half_t       cfg_dir [2];

  assign wr_stat = bus_we && (bus_addr == A_STAT);
  assign wr_mask = bus_we && (bus_addr == A_MASK);
  assign wr_dly  = bus_we && (bus_addr == A_DLY);

  assign ev_dir[0]  = EV_W'(tx_done);
  assign ev_dir[1]  = EV_W'(rx_done);
  assign cfg_dir[0] = dly_half_t'(dly_q[31:16]);
  assign cfg_dir[1] = dly_half_t'(dly_q[15:0]);

  for (genvar d = 0; d < 2; d++) begin : g_dir
    hs_coal_half #(.EV_W(EV_W)) u_half (
      .clk  (clk),
      .rst_n(rst_n),
      .cfg  (cfg_dir[d]),
      .ev   (ev_dir[d]),
      .tick (tick),
      .fire (fire[d])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[TX_Q-1:0]              = tx_done;
    set_vec[RX_DONE_LSB +: RX_Q]   = rx_done;
    set_vec[BIT_TX_DLY]            = fire[0];
    set_vec[BIT_TX_COH]            = fire[0];
    set_vec[BIT_RX_DLY]            = fire[1];
    set_vec[BIT_RX_COH]            = fire[1];
  end

  hs_stat_reg #(.W(32), .IMPL(IMPL)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_we  (wr_stat),
    .clr_data(bus_wdata),
    .stat    (stat_q)
  );

  always_comb begin
    mask_d = bus_wdata & IMPL;
    dly_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dly_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= mask_d;
      if (wr_dly)  dly_q  <= dly_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = stat_q;
      A_MASK:  bus_rdata = mask_q;
      A_DLY:   bus_rdata = dly_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/hs_irq_coalesce_chk.sv
module hs_irq_coalesce_chk
  import hs_irq_pkg::*;
#(
  parameter int unsigned TX_Q   = 4,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TX_Q-1:0]   tx_done,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic [31:0]       stat_q,
  input logic [31:0]       mask_q,
  input logic [31:0]       dly_q
);
  logic wr_stat;
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFS_STAT));

  assert_txdone_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done != '0) |=> ((stat_q[TX_Q-1:0] & $past(tx_done)) == $past(tx_done)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && tx_done == '0) |=> $stable(stat_q[TX_Q-1:0]));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q[TX_Q-1:0] & $past(bus_wdata[TX_Q-1:0] & ~tx_done)) == '0));

  assert_mask_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_dly_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[BIT_TX_DLY]) |-> $past(dly_q[31]));

  assert_coh_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[BIT_RX_DLY]) |-> stat_q[BIT_RX_COH]);
endmodule

bind hs_irq_coalesce hs_irq_coalesce_chk #(.TX_Q(TX_Q), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_done  (tx_done),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .stat_q   (stat_q),
  .mask_q   (mask_q),
  .dly_q    (dly_q)
);

// File: tb/tb_hs_irq_coalesce.sv
module tb_hs_irq_coalesce;
  localparam logic [11:0] A_STAT = 12'h220;
  localparam logic [11:0] A_MASK = 12'h228;
  localparam logic [11:0] A_DLY  = 12'h20C;
  localparam int NV = 7;
  // {tx[3:0], rx[1:0], wr_stat, wdata[31:0], expected status[31:0]}
  localparam logic [70:0] VEC [NV] = '{
    {4'b0001, 2'b00, 1'b0, 32'h0,         32'h0000_0001},
    {4'b0000, 2'b01, 1'b0, 32'h0,         32'h0001_0001},
    {4'b1000, 2'b10, 1'b0, 32'h0,         32'h0003_0009},
    {4'b0000, 2'b00, 1'b1, 32'h0000_0001, 32'h0003_0008},
    {4'b0010, 2'b00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0002},
    {4'b0000, 2'b00, 1'b1, 32'h0,         32'h0000_0002},
    {4'b0000, 2'b00, 1'b1, 32'h0000_0002, 32'h0000_0000}
  };

  logic        clk, rst_n, tick, bus_we, irq;
  logic [3:0]  tx_done;
  logic [1:0]  rx_done;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0, errors = 0;

  hs_irq_coalesce dut (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .rx_done(rx_done), .tick(tick),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] tx, input logic [1:0] rx, input logic tk,
                      input logic we, input logic [11:0] a, input logic [31:0] wd);
    @(negedge clk);
    tx_done = tx; rx_done = rx; tick = tk; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    tx_done = '0; rx_done = '0; tick = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd);
    step(4'b0, 2'b0, 1'b0, 1'b1, a, wd);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v, exp, req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    tx_done = '0; rx_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(A_STAT, 32'h0, "R1 status");
    rd_chk(A_MASK, 32'h0, "R1 mask");
    rd_chk(A_DLY,  32'h0, "R1 delay");
    chk({31'h0, irq}, 32'h0, "R1 irq");

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][70:67], VEC[i][66:65], 1'b0, VEC[i][64], A_STAT, VEC[i][63:32]);
      rd_chk(A_STAT, VEC[i][31:0], "R2/R3/R4 vector");
    end

    // R3 non-functional bits and zeros ignored
    step(4'b0011, 2'b00, 1'b0, 1'b0, A_STAT, 32'h0);
    wr(A_STAT, 32'h0FFC_FFF0);
    rd_chk(A_STAT, 32'h0000_0003, "R3 unaffected bits");
    wr(A_STAT, 32'hFFFF_FFFF);

    // R6 delay word readback
    wr(A_DLY, 32'h1234_5678);
    rd_chk(A_DLY, 32'h1234_5678, "R6 readback");

    // R7 count threshold 3 on transmit half, R10 companion
    wr(A_DLY, 32'h8300_0000);
    step(4'b0011, 2'b00, 1'b0, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h0000_0003, "R7 below threshold");
    step(4'b0001, 2'b00, 1'b0, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h3000_0003, "R7/R10 threshold reached");
    wr(A_STAT, 32'hFFFF_FFFF);
    step(4'b0001, 2'b00, 1'b0, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h0000_0001, "R7 count restarted");

    // R11 receive events do not advance transmit count
    wr(A_STAT, 32'hFFFF_FFFF);
    for (int k = 0; k < 5; k++) step(4'b0, 2'b01, 1'b0, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h0001_0000, "R11 direction isolation");

    // R8 tick limit 4 on receive half
    wr(A_DLY, 32'h0000_8004);
    wr(A_STAT, 32'hFFFF_FFFF);
    step(4'b0, 2'b01, 1'b0, 1'b0, A_STAT, 32'h0);
    for (int k = 0; k < 3; k++) step(4'b0, 2'b00, 1'b1, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h0001_0000, "R8 one tick short");
    step(4'b0, 2'b00, 1'b1, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'hC001_0000, "R8/R10 limit reached");

    // R9 zero fields and clear enable
    wr(A_DLY, 32'h8000_8000);
    wr(A_STAT, 32'hFFFF_FFFF);
    for (int k = 0; k < 10; k++) step(4'b1111, 2'b11, 1'b1, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h0003_000F, "R9 zero fields");
    wr(A_DLY, 32'h0103_0103);
    wr(A_STAT, 32'hFFFF_FFFF);
    for (int k = 0; k < 5; k++) step(4'b0001, 2'b01, 1'b1, 1'b0, A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h0001_0001, "R9 enable clear");

    // R5 mask and irq
    wr(A_DLY, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_MASK, 32'h0001_0000);
    rd_chk(A_MASK, 32'h0001_0000, "R5 mask readback");
    chk({31'h0, irq}, 32'h0, "R5 irq idle");
    step(4'b0001, 2'b00, 1'b0, 1'b0, A_STAT, 32'h0);
    chk({31'h0, irq}, 32'h0, "R5 unmasked bit quiet");
    step(4'b0000, 2'b01, 1'b0, 1'b0, A_STAT, 32'h0);
    chk({31'h0, irq}, 32'h1, "R5 masked event");
    wr(A_MASK, 32'hFFFF_FFFF);
    rd_chk(A_MASK, 32'hF003_000F, "R5 implemented mask bits");
    wr(A_STAT, 32'h0001_0000);
    chk({31'h0, irq}, 32'h1, "R5 remaining tx bit");
    wr(A_STAT, 32'hFFFF_FFFF);
    chk({31'h0, irq}, 32'h0, "R5 all cleared");

    // R1 mid-run reset
    step(4'b1111, 2'b11, 1'b0, 1'b0, A_STAT, 32'h0);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    rd_chk(A_STAT, 32'h0, "R1 reset clears status");
    rd_chk(A_MASK, 32'h0, "R1 reset clears mask");
    chk({31'h0, irq}, 32'h0, "R1 reset irq");
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule